// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Page Walker

This block turns a 32-bit linear address into a physical page frame. It does this by walking a two-level page table held in memory, using the 32-bit entry format without physical address extension. A client presents a request that carries the linear address and a write flag. The walker then works through these steps:

- It fetches the directory entry. When that entry marks a large page and large pages are enabled, the walk stops there with a 4 MB page.
- Otherwise it marks the directory entry as used and fetches the table entry.
- It asks an external permission block whether the combined protection bits allow the access.
- It stores updated accessed and dirty flags back into the final entry.

Every entry address is masked with the address-wrap mask before it is used.

All memory traffic goes through one port with a request/ready handshake and at most one access in flight. The permission decision is made outside this block. The walker sends out the combined protection word for one cycle and reads the pass/fail answer in the cycle after. The result (frame, virtual page base, page size, protection word and fault kind) stays on the outputs until the client acknowledges it. A new request is accepted only while the walker is idle.

Top module: `lin2phys_walker`

## Requirements
- R1: On acceptance, the first read goes to ((root_base_i with bits 11:0 cleared) + 4 × req_addr_i[31:22]) ANDed with a20_mask_i.
- R2: If bit 0 (present) of the directory entry is 0, the walk ends with rsp_fault_o = 1 (absent) and makes no further memory access. Fault kinds are 0 = none, 1 = absent, 2 = protection.
- R3: If directory bit 7 and big_page_en_i are both 1, the page is 4 MB and no second read is made. In that case: rsp_big_o = 1; rsp_prot_o is the directory entry as read; rsp_frame_o is the updated entry with bits 21:12 cleared; rsp_vbase_o is the address with bits 21:0 cleared.
- R4: If directory bit 7 is set while big_page_en_i is 0, the walk continues as a normal two-level 4 KB walk.
- R5: For a 4 KB walk whose directory entry has bit 5 (accessed) clear, the same directory address is first written with bit 5 set. The table read comes only after that write.
- R6: The table entry address is ((directory entry with bits 11:0 cleared) + 4 × address bits 21:12) ANDed with the latched wrap mask.
- R7: A table entry with bit 0 clear ends the walk with rsp_fault_o = 1.
- R8: For a 4 KB page, the protection word sent to the permission block and returned on rsp_prot_o is the bitwise AND of the table and directory entries.
- R9: perm_query_o is high for one cycle and carries perm_bits_o and perm_write_o. perm_pass_i is sampled in the next cycle. A 0 gives rsp_fault_o = 2 and no write to the final entry.
- R10: After a pass, the final entry gets bit 5 set, and also bit 6 (dirty) when the access is a write. It is written back only if its value changed. The returned frame includes the updated bits.
- R11: mem_req_o, with its address, write flag and write data, stays stable until mem_ready_i. The result stays valid and stable until rsp_ack_i. req_ready_o is high only when idle, and after reset it is high with no memory request.
- R12: For a 4 KB page, rsp_frame_o is the updated table entry, rsp_vbase_o is the address with bits 11:0 cleared, and rsp_big_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Translation request |
| req_addr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_ready_o | output | 1 | Walker idle, request accepted |
| root_base_i | input | 32 | Directory base (low 12 bits ignored) |
| big_page_en_i | input | 1 | Enables 4 MB pages |
| a20_mask_i | input | 32 | Mask applied to every entry address |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i on reads |
| perm_query_o | output | 1 | Permission query strobe |
| perm_bits_o | output | 32 | Combined protection word |
| perm_write_o | output | 1 | Access type for the query |
| perm_pass_i | input | 1 | Permission answer, cycle after query |
| rsp_valid_o | output | 1 | Result valid |
| rsp_fault_o | output | 2 | 0 none, 1 absent, 2 protection |
| rsp_frame_o | output | 32 | Page-aligned frame with low attribute bits |
| rsp_vbase_o | output | 32 | Linear page base |
| rsp_big_o | output | 1 | 4 MB page |
| rsp_prot_o | output | 32 | Combined protection word |
| rsp_ack_i | input | 1 | Result consumed |

## Verification
A wrong walk state shows up at the memory port as early as the next access. It can appear as a read at the wrong entry address, a missing or extra write of the directory entry, or a second read after a large-page hit. The bench counts and logs every read and write for each walk, so a misstep is caught at the first wrong access. A corrupted entry register or wrong merging of protections shows up one cycle later on perm_bits_o. The same fault appears again on the held result: the frame, page base and fault kind are compared once rsp_valid_o rises. Results are also held for several cycles before acknowledgement to catch drift.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
  localparam int unsigned B_PRESENT = 0;
  localparam int unsigned B_ACC     = 5;
  localparam int unsigned B_DIRTY   = 6;
  localparam int unsigned B_LARGE   = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_RD, S_DIR_WR, S_TBL_RD, S_PERM_Q, S_PERM_W, S_FIN_WR, S_DONE
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_PROT   = 2'd2
  } walk_flt_e;
endpackage

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
module ptw_entry_addr #(
  parameter int AW      = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10,
  parameter int IDX_LSB = 22
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] wrap_mask_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LOW_MASK = (AW'(1) << OFF_W) - AW'(1);
  logic [AW-1:0] slot_off;
  // each entry is four bytes wide
  assign slot_off = AW'(vaddr_i[IDX_LSB +: IDX_W]) << 2;
  assign addr_o   = ((base_i & ~LOW_MASK) + slot_off) & wrap_mask_i;
endmodule

// File: rtl/ptw_ad_update.sv
`timescale 1ns/1ps
module ptw_ad_update #(
  parameter int DW    = 32,
  parameter int ACC_B = 5,
  parameter int DRT_B = 6
) (
  input  logic [DW-1:0] entry_i,
  input  logic          write_i,
  output logic [DW-1:0] entry_o,
  output logic          change_o
);
  always_comb begin
    entry_o        = entry_i;
    entry_o[ACC_B] = 1'b1;
    if (write_i) entry_o[DRT_B] = 1'b1;
  end
  assign change_o = (entry_o != entry_i);
endmodule

// File: rtl/ptw_result_fmt.sv
`timescale 1ns/1ps
module ptw_result_fmt #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic [AW-1:0] entry_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic          big_i,
  output logic [AW-1:0] frame_o,
  output logic [AW-1:0] vbase_o
);
  localparam int BIG_W = OFF_W + IDX_W;
  localparam logic [AW-1:0] SMALL_OFS = (AW'(1) << OFF_W) - AW'(1);
  localparam logic [AW-1:0] BIG_OFS   = (AW'(1) << BIG_W) - AW'(1);
  localparam logic [AW-1:0] MID_MASK  = BIG_OFS & ~SMALL_OFS;

  always_comb begin
    if (big_i) begin
      frame_o = entry_i & ~MID_MASK;
      vbase_o = vaddr_i & ~BIG_OFS;
    end else begin
      frame_o = entry_i;
      vbase_o = vaddr_i & ~SMALL_OFS;
    end
  end
endmodule

// File: rtl/lin2phys_walker.sv
`timescale 1ns/1ps
module lin2phys_walker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] root_base_i,
  input  logic          big_page_en_i,
  input  logic [AW-1:0] a20_mask_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          perm_query_o,
  output logic [AW-1:0] perm_bits_o,
  output logic          perm_write_o,
  input  logic          perm_pass_i,
  output logic          rsp_valid_o,
  output logic [1:0]    rsp_fault_o,
  output logic [AW-1:0] rsp_frame_o,
  output logic [AW-1:0] rsp_vbase_o,
  output logic          rsp_big_o,
  output logic [AW-1:0] rsp_prot_o,
  input  logic          rsp_ack_i
);
  import ptw_pkg::*;

  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int TBL_LSB = OFF_W;

  walk_st_e      st;
  walk_flt_e     fault_q;
  logic [AW-1:0] va_q, a20_q, dir_q, fin_q, fin_addr_q, prot_q;
  logic          wr_q, big_q;
  logic          mreq_q, mwe_q;
  logic [AW-1:0] maddr_q, mwdata_q;

  logic [AW-1:0] dir_addr, tbl_addr, tbl_base;
  logic [AW-1:0] dir_marked, fin_upd;
  logic          dir_mark_chg, fin_chg;
  logic          xfer;

  assign xfer = mreq_q && mem_ready_i;

  ptw_entry_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .IDX_LSB(DIR_LSB)) u_dir_addr (
    .base_i(root_base_i), .vaddr_i(req_addr_i), .wrap_mask_i(a20_mask_i), .addr_o(dir_addr)
  );

  // the table base comes straight from the read data unless the directory entry was rewritten
  assign tbl_base = (st == S_DIR_RD) ? mem_rdata_i : dir_q;

  ptw_entry_addr #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W), .IDX_LSB(TBL_LSB)) u_tbl_addr (
    .base_i(tbl_base), .vaddr_i(va_q), .wrap_mask_i(a20_q), .addr_o(tbl_addr)
  );

  ptw_ad_update #(.DW(AW), .ACC_B(B_ACC), .DRT_B(B_DIRTY)) u_dir_mark (
    .entry_i(mem_rdata_i), .write_i(1'b0), .entry_o(dir_marked), .change_o(dir_mark_chg)
  );

  ptw_ad_update #(.DW(AW), .ACC_B(B_ACC), .DRT_B(B_DIRTY)) u_fin_mark (
    .entry_i(fin_q), .write_i(wr_q), .entry_o(fin_upd), .change_o(fin_chg)
  );

  ptw_result_fmt #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_fmt (
    .entry_i(fin_q), .vaddr_i(va_q), .big_i(big_q), .frame_o(rsp_frame_o), .vbase_o(rsp_vbase_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      fault_q    <= FLT_NONE;
      va_q       <= '0;
      a20_q      <= '0;
      dir_q      <= '0;
      fin_q      <= '0;
      fin_addr_q <= '0;
      prot_q     <= '0;
      wr_q       <= 1'b0;
      big_q      <= 1'b0;
      mreq_q     <= 1'b0;
      mwe_q      <= 1'b0;
      maddr_q    <= '0;
      mwdata_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_addr_i;
          wr_q    <= req_write_i;
          a20_q   <= a20_mask_i;
          fault_q <= FLT_NONE;
          big_q   <= 1'b0;
          mreq_q  <= 1'b1;
          mwe_q   <= 1'b0;
          maddr_q <= dir_addr;
          st      <= S_DIR_RD;
        end
        S_DIR_RD: if (xfer) begin
          if (!mem_rdata_i[B_PRESENT]) begin
            mreq_q  <= 1'b0;
            fault_q <= FLT_ABSENT;
            st      <= S_DONE;
          end else if (mem_rdata_i[B_LARGE] && big_page_en_i) begin
            mreq_q     <= 1'b0;
            big_q      <= 1'b1;
            fin_q      <= mem_rdata_i;
            fin_addr_q <= maddr_q;
            prot_q     <= mem_rdata_i;
            st         <= S_PERM_Q;
          end else if (dir_mark_chg) begin
            dir_q    <= dir_marked;
            mwe_q    <= 1'b1;
            mwdata_q <= dir_marked;
            st       <= S_DIR_WR;
          end else begin
            dir_q   <= mem_rdata_i;
            maddr_q <= tbl_addr;
            st      <= S_TBL_RD;
          end
        end
        S_DIR_WR: if (xfer) begin
          mwe_q   <= 1'b0;
          maddr_q <= tbl_addr;
          st      <= S_TBL_RD;
        end
        S_TBL_RD: if (xfer) begin
          mreq_q <= 1'b0;
          if (!mem_rdata_i[B_PRESENT]) begin
            fault_q <= FLT_ABSENT;
            st      <= S_DONE;
          end else begin
            fin_q      <= mem_rdata_i;
            fin_addr_q <= maddr_q;
            prot_q     <= mem_rdata_i & dir_q;
            st         <= S_PERM_Q;
          end
        end
        S_PERM_Q: st <= S_PERM_W;
        S_PERM_W: begin
          if (!perm_pass_i) begin
            fault_q <= FLT_PROT;
            st      <= S_DONE;
          end else if (fin_chg) begin
            fin_q    <= fin_upd;
            mreq_q   <= 1'b1;
            mwe_q    <= 1'b1;
            maddr_q  <= fin_addr_q;
            mwdata_q <= fin_upd;
            st       <= S_FIN_WR;
          end else begin
            st <= S_DONE;
          end
        end
        S_FIN_WR: if (xfer) begin
          mreq_q <= 1'b0;
          mwe_q  <= 1'b0;
          st     <= S_DONE;
        end
        S_DONE: if (rsp_ack_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (st == S_IDLE);
  assign mem_req_o    = mreq_q;
  assign mem_we_o     = mwe_q;
  assign mem_addr_o   = maddr_q;
  assign mem_wdata_o  = mwdata_q;
  assign perm_query_o = (st == S_PERM_Q);
  assign perm_bits_o  = prot_q;
  assign perm_write_o = wr_q;
  assign rsp_valid_o  = (st == S_DONE);
  assign rsp_fault_o  = fault_q;
  assign rsp_big_o    = big_q;
  assign rsp_prot_o   = prot_q;

  // R11: a pending memory access keeps its attributes until it is taken
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o));

  // R11: an unacknowledged result stays put
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_o && !rsp_ack_i |=> rsp_valid_o && $stable(rsp_frame_o) && $stable(rsp_fault_o)
                                  && $stable(rsp_prot_o));

  // R1, R6: no entry access ever lands outside the latched wrap mask
  p_wrap_mask_r1: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> ((mem_addr_o & ~a20_q) == '0));

  // R5, R10: every write-back carries the accessed flag
  p_wr_marks_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_we_o |-> mem_wdata_o[B_ACC]);

  // R9: a denial ends the walk without touching memory
  p_deny_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_PERM_W) && !perm_pass_i |=> !mem_req_o && rsp_valid_o && (rsp_fault_o == 2'd2));

  // R9: a query is a single-cycle strobe
  p_query_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    perm_query_o |=> !perm_query_o);
endmodule

// File: tb/lin2phys_walker_tb_top.sv
`timescale 1ns/1ps
module lin2phys_walker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, big_en = 0, mem_ready = 0, perm_pass = 1, rsp_ack = 0;
  logic [31:0] req_addr = 0, root = 32'h0000_1000, a20 = 32'hFFFF_FFFF, mem_rdata = 0;
  logic        req_ready, mem_req, mem_we, perm_query, perm_write, rsp_valid, rsp_big;
  logic [31:0] mem_addr, mem_wdata, perm_bits, rsp_frame, rsp_vbase, rsp_prot;
  logic [1:0]  rsp_fault;

  lin2phys_walker dut_i (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write), .req_ready_o(req_ready),
    .root_base_i(root), .big_page_en_i(big_en), .a20_mask_i(a20),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .perm_query_o(perm_query), .perm_bits_o(perm_bits), .perm_write_o(perm_write),
    .perm_pass_i(perm_pass),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_frame_o(rsp_frame),
    .rsp_vbase_o(rsp_vbase), .rsp_big_o(rsp_big), .rsp_prot_o(rsp_prot), .rsp_ack_i(rsp_ack)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  int          rd_cnt, wr_cnt, q_cnt;
  logic [31:0] rd_a [0:3];
  logic [31:0] wr_a [0:3];
  logic [31:0] wr_d [0:3];
  logic [31:0] q_bits;
  logic        q_write;

  logic [1:0]  r_fault;
  logic [31:0] r_frame, r_vbase, r_prot;
  logic        r_big;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: each request completes after lat idle cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 0;
        cnt = 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ready = 1;
          if (mem_we) begin
            mem[mem_addr] = mem_wdata;
            if (wr_cnt < 4) begin wr_a[wr_cnt] = mem_addr; wr_d[wr_cnt] = mem_wdata; end
            wr_cnt++;
          end else begin
            mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            if (rd_cnt < 4) rd_a[rd_cnt] = mem_addr;
            rd_cnt++;
          end
        end else cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (perm_query) begin q_cnt++; q_bits = perm_bits; q_write = perm_write; end
    end
  end

  task automatic walk(input logic [31:0] a, input logic w, input int hold);
    rd_cnt = 0; wr_cnt = 0; q_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w;
    do @(negedge clk); while (req_ready);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    r_fault = rsp_fault; r_frame = rsp_frame; r_vbase = rsp_vbase; r_prot = rsp_prot; r_big = rsp_big;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R11 held valid", {31'b0, rsp_valid}, 32'h1);
      chk("R11 held frame", rsp_frame, r_frame);
      chk("R11 busy not ready", {31'b0, req_ready}, 32'h0);
    end
    rsp_ack = 1;
    @(negedge clk);
    rsp_ack = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset ready", {31'b0, req_ready}, 32'h1);
    chk("R11 reset no mem", {31'b0, mem_req}, 32'h0);
    chk("R11 reset no rsp", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_small_read;
    mem.delete();
    mem[32'h1004] = 32'h0000_2027;
    mem[32'h2014] = 32'h0ABC_D007;
    perm_pass = 1; big_en = 0;
    walk(32'h0040_5123, 0, 0);
    chk("R1 dir addr", rd_a[0], 32'h1004);
    chk("R6 tbl addr", rd_a[1], 32'h2014);
    chk("R8 prot merge", r_prot, 32'h0000_0007);
    chk("R8 query bits", q_bits, 32'h0000_0007);
    chk("R9 one query", q_cnt, 1);
    chk("R10 acc write cnt", wr_cnt, 1);
    chk("R10 acc write data", wr_d[0], 32'h0ABC_D027);
    chk("R12 frame", r_frame, 32'h0ABC_D027);
    chk("R12 vbase", r_vbase, 32'h0040_5000);
    chk("R12 small", {31'b0, r_big}, 32'h0);
    chk("R12 no fault", {30'b0, r_fault}, 32'h0);
  endtask

  task automatic t_dir_mark;
    mem.delete();
    mem[32'h1004] = 32'h0000_2007;
    mem[32'h2014] = 32'h0ABC_D067;
    walk(32'h0040_5123, 0, 0);
    chk("R5 dir write first", wr_a[0], 32'h1004);
    chk("R5 dir write data", wr_d[0], 32'h0000_2027);
    chk("R5 one write only", wr_cnt, 1);
    chk("R5 table read after", rd_a[1], 32'h2014);
    chk("R5 memory updated", mem[32'h1004], 32'h0000_2027);
  endtask

  task automatic t_dirty;
    mem.delete();
    mem[32'h1004] = 32'h0000_2027;
    mem[32'h2014] = 32'h0ABC_D027;
    walk(32'h0040_5123, 1, 0);
    chk("R10 write sets dirty", wr_d[0], 32'h0ABC_D067);
    chk("R9 query write flag", {31'b0, q_write}, 32'h1);
    chk("R10 frame has dirty", r_frame, 32'h0ABC_D067);
    walk(32'h0040_5123, 1, 0);
    chk("R10 unchanged no write", wr_cnt, 0);
  endtask

  task automatic t_big;
    mem.delete();
    mem[32'h10C0] = 32'h124F_F0A7;
    big_en = 1;
    walk(32'h0C12_3456, 0, 0);
    chk("R3 single read", rd_cnt, 1);
    chk("R3 big flag", {31'b0, r_big}, 32'h1);
    chk("R3 prot is dir", r_prot, 32'h124F_F0A7);
    chk("R3 frame", r_frame, 32'h1240_00A7);
    chk("R3 vbase", r_vbase, 32'h0C00_0000);
    chk("R3 no write", wr_cnt, 0);
  endtask

  task automatic t_big_off;
    mem.delete();
    mem[32'h10C0] = 32'h124F_F0A7;
    mem[32'h124F_F48C] = 32'h0005_5005;
    big_en = 0;
    walk(32'h0C12_3456, 0, 0);
    chk("R4 two reads", rd_cnt, 2);
    chk("R4 tbl addr", rd_a[1], 32'h124F_F48C);
    chk("R4 small page", {31'b0, r_big}, 32'h0);
    chk("R4 frame", r_frame, 32'h0005_5025);
  endtask

  task automatic t_absent;
    mem.delete();
    mem[32'h1004] = 32'h0000_2026;
    walk(32'h0040_5123, 1, 0);
    chk("R2 fault kind", {30'b0, r_fault}, 32'h1);
    chk("R2 one read", rd_cnt, 1);
    chk("R2 no write", wr_cnt, 0);
    chk("R2 no query", q_cnt, 0);
    mem[32'h1004] = 32'h0000_2027;
    mem[32'h2014] = 32'h0ABC_D006;
    walk(32'h0040_5123, 0, 0);
    chk("R7 fault kind", {30'b0, r_fault}, 32'h1);
    chk("R7 no write", wr_cnt, 0);
  endtask

  task automatic t_deny;
    mem.delete();
    mem[32'h1004] = 32'h0000_2025;
    mem[32'h2014] = 32'h0ABC_D003;
    perm_pass = 0;
    walk(32'h0040_5123, 1, 0);
    chk("R9 prot fault", {30'b0, r_fault}, 32'h2);
    chk("R9 no write back", wr_cnt, 0);
    chk("R9 entry untouched", mem[32'h2014], 32'h0ABC_D003);
    chk("R8 query merge", q_bits, 32'h0000_0001);
    perm_pass = 1;
  endtask

  task automatic t_wrap;
    mem.delete();
    root = 32'h0010_1000; a20 = 32'hFFEF_FFFF;
    mem[32'h0000_1004] = 32'h0012_0027;
    mem[32'h0002_0014] = 32'h0077_7067;
    walk(32'h0040_5123, 0, 0);
    chk("R1 masked dir addr", rd_a[0], 32'h0000_1004);
    chk("R6 masked tbl addr", rd_a[1], 32'h0002_0014);
    chk("R10 no change no write", wr_cnt, 0);
    chk("R12 frame", r_frame, 32'h0077_7067);
    root = 32'h0000_1000; a20 = 32'hFFFF_FFFF;
  endtask

  task automatic t_slow;
    mem.delete();
    mem[32'h1004] = 32'h0000_2007;
    mem[32'h2014] = 32'h0ABC_D007;
    lat = 3;
    walk(32'h0040_5123, 1, 4);
    chk("R11 slow writes", wr_cnt, 2);
    chk("R11 slow frame", r_frame, 32'h0ABC_D067);
    lat = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_small_read();
    t_dir_mark();
    t_dirty();
    t_big();
    t_big_off();
    t_absent();
    t_deny();
    t_wrap();
    t_slow();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule